// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous static memory whose data bus stays fully busy when reads and writes alternate. Command, address and byte mask are captured on a rising clock edge. The data belonging to that command is on the shared bidirectional bus two edges later, for reads and for writes alike. Because both directions have the same latency, a write can follow a read, or a read a write, with no idle cycle between them. A small internal array stands in for the real storage.

A load (`ld_n` low) with all three chip selects active starts a new operation at the external address. It also opens a four-beat burst. Each later advance cycle (`ld_n` high) issues the next burst address of the same type. The burst order is either linear or interleaved, chosen by `burst_lin`.

The burst tracker is a three-state machine:
- `ST_IDLE`: no burst.
- `ST_RD`: read burst open.
- `ST_WR`: write burst open.

Its transitions are:
- LOAD_RD: a selected load with `wr_n` high, into `ST_RD`.
- LOAD_WR: a selected load with `wr_n` low, into `ST_WR`.
- DESELECT: a load with any chip select inactive, into `ST_IDLE`.
- ADVANCE: `ld_n` high, which keeps the state. It steps the beat counter when a burst is open and does nothing in `ST_IDLE`.

A held clock enable freezes every state change.

Top module: `zt_sram`

## Requirements
- R1: A read issued at rising edge n has its word on `dq`, driven by the block, during the cycle that ends at edge n+2.
- R2: A write issued at edge n takes its data from `dq` at edge n+2. A read may be issued on the very next edge, and a write on the edge after a read, with no idle cycle.
- R3: On a write, lane i (bits i*BW to i*BW+BW-1 of `dq`) is stored only when `byte_we_n[i]` was 0 with the command. A lane whose bit was 1 keeps its old contents.
- R4: While `cke_n` is 1, the block ignores all synchronous inputs. The pipeline, the burst state and the read output hold, so a word already on the bus stays there, and a command presented during the stall is never executed.
- R5: A load cycle with `cs1_n`=1, `cs2`=0 or `cs3_n`=1 starts no operation and closes any open burst. Later advance cycles then issue nothing. Operations already in the pipeline still complete.
- R6: The block drives `dq` only in the data cycle of a read. It releases the bus in the data cycle of a write, of a deselect and of an idle advance.
- R7: `oe_n`=1 releases `dq` immediately, without disturbing the pipeline.
- R8: Burst beat k (k = 0 at the load) addresses base with its two low bits replaced by (base+k) mod 4 when `burst_lin`=1, or by base XOR k when `burst_lin`=0. The upper bits stay fixed, and the sequence wraps after four beats.
- R9: A read issued on the edge right after a write to the same word returns the lanes that write stores, merged with the old contents of the other lanes.
- R10: While `rst_n` is 0 and after its release, nothing is pending and `dq` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of pipeline and burst state |
| cke_n | input | 1 | Active-low clock enable; 1 stalls the whole block |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | 0 loads a new command, 1 advances the burst |
| wr_n | input | 1 | 0 write, 1 read (sampled on a load) |
| byte_we_n | input | NB | Active-low write enable per byte lane |
| oe_n | input | 1 | Asynchronous active-low output enable |
| burst_lin | input | 1 | 1 linear burst order, 0 interleaved |
| addr | input | AW | Word address (sampled on a load) |
| dq | inout | NB*BW | Shared data bus |

## Verification
The hardest state to reach is a read that meets a write to the same word while the write is still in flight. The stimulus issues a masked write and, on the next edge, a read of that word. It then drives the write data on the bus in the read's first pipeline cycle, so the expected word is a lane-wise merge of old and new data. A second hard case is a clock-enable stall that lands exactly while read data is on the bus. The stall cycles also carry a competing write command, which is read back afterwards to confirm it never took effect.

// File: rtl/zt_pkg.sv
package zt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } burst_st_e;
endpackage

// File: rtl/zt_issue.sv
module zt_issue
    import zt_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cke_n,
    input  logic          ld_n,
    input  logic          sel_ok,
    input  logic          wr_n,
    input  logic          burst_lin,
    input  logic [AW-1:0] addr,
    output logic          issue_vld,
    output logic          issue_wr,
    output logic [AW-1:0] issue_addr,
    output burst_st_e     st
);
    localparam int CW = 2;

    burst_st_e      st_nxt;
    logic [AW-1:0]  base_q;
    logic [CW-1:0]  beat_q;
    logic [CW-1:0]  beat_nxt;
    logic [CW-1:0]  beat_inc;
    logic [CW-1:0]  low_bits;

    // next-state: LOAD_RD, LOAD_WR, DESELECT, ADVANCE
    always_comb begin
        st_nxt   = st;
        beat_nxt = beat_q;
        if (!ld_n) begin
            beat_nxt = '0;
            if (!sel_ok)    st_nxt = ST_IDLE;
            else if (wr_n)  st_nxt = ST_RD;
            else            st_nxt = ST_WR;
        end else begin
            unique case (st)
                ST_IDLE:      st_nxt   = ST_IDLE;
                ST_RD, ST_WR: beat_nxt = beat_q + 1'b1;
                default:      st_nxt   = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            beat_q <= '0;
            base_q <= '0;
        end else if (!cke_n) begin
            st     <= st_nxt;
            beat_q <= beat_nxt;
            if (!ld_n) base_q <= addr;
        end
    end

    assign beat_inc = beat_q + 1'b1;
    assign low_bits = burst_lin ? (base_q[CW-1:0] + beat_inc)
                                : (base_q[CW-1:0] ^ beat_inc);

    // outputs
    always_comb begin
        issue_vld  = 1'b0;
        issue_wr   = 1'b0;
        issue_addr = {base_q[AW-1:CW], low_bits};
        if (!ld_n) begin
            issue_vld  = sel_ok;
            issue_wr   = !wr_n;
            issue_addr = addr;
        end else begin
            unique case (st)
                ST_IDLE: issue_vld = 1'b0;
                ST_RD:   issue_vld = 1'b1;
                ST_WR: begin
                    issue_vld = 1'b1;
                    issue_wr  = 1'b1;
                end
                default: issue_vld = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/zt_pipe.sv
module zt_pipe #(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cke_n,
    input  logic          issue_vld,
    input  logic          issue_wr,
    input  logic [AW-1:0] issue_addr,
    input  logic [NB-1:0] issue_bwe_n,
    output logic          s1_vld,
    output logic          s1_wr,
    output logic [AW-1:0] s1_addr,
    output logic [NB-1:0] s1_bwe_n,
    output logic          s2_vld,
    output logic          s2_wr,
    output logic [AW-1:0] s2_addr,
    output logic [NB-1:0] s2_bwe_n
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_wr    <= 1'b0;
            s1_addr  <= '0;
            s1_bwe_n <= '1;
            s2_vld   <= 1'b0;
            s2_wr    <= 1'b0;
            s2_addr  <= '0;
            s2_bwe_n <= '1;
        end else if (!cke_n) begin
            s1_vld   <= issue_vld;
            s1_wr    <= issue_wr;
            s1_addr  <= issue_addr;
            s1_bwe_n <= issue_bwe_n;
            s2_vld   <= s1_vld;
            s2_wr    <= s1_wr;
            s2_addr  <= s1_addr;
            s2_bwe_n <= s1_bwe_n;
        end
    end
endmodule

// File: rtl/zt_store.sv
module zt_store #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             s1_vld,
    input  logic             s1_wr,
    input  logic [AW-1:0]    s1_addr,
    input  logic             s2_vld,
    input  logic             s2_wr,
    input  logic [AW-1:0]    s2_addr,
    input  logic [NB-1:0]    s2_bwe_n,
    input  logic [NB*BW-1:0] din,
    output logic [NB*BW-1:0] dout
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = NB * BW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_merge;
    logic          hit;

    assign hit = s2_vld && s2_wr && (s2_addr == s1_addr);

    for (genvar l = 0; l < NB; l++) begin : g_lane
        assign rd_merge[l*BW +: BW] = (hit && !s2_bwe_n[l]) ? din[l*BW +: BW]
                                                             : mem[s1_addr][l*BW +: BW];
    end

    always_ff @(posedge clk) begin
        if (!cke_n && s2_vld && s2_wr) begin
            for (int l = 0; l < NB; l++) begin
                if (!s2_bwe_n[l]) mem[s2_addr][l*BW +: BW] <= din[l*BW +: BW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                           dout <= '0;
        else if (!cke_n && s1_vld && !s1_wr)  dout <= rd_merge;
    end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cke_n,
    input  logic                cs1_n,
    input  logic                cs2,
    input  logic                cs3_n,
    input  logic                ld_n,
    input  logic                wr_n,
    input  logic [NB-1:0]       byte_we_n,
    input  logic                oe_n,
    input  logic                burst_lin,
    input  logic [AW-1:0]       addr,
    inout  wire  [NB*BW-1:0]    dq
);
    localparam int DW = NB * BW;

    logic          sel_ok;
    logic          issue_vld;
    logic          issue_wr;
    logic [AW-1:0] issue_addr;
    burst_st_e     st;
    logic          s1_vld, s1_wr, s2_vld, s2_wr;
    logic [AW-1:0] s1_addr, s2_addr;
    logic [NB-1:0] s1_bwe_n, s2_bwe_n;
    logic [DW-1:0] dout;
    logic          dq_oe;

    assign sel_ok = !cs1_n && cs2 && !cs3_n;

    zt_issue #(.AW(AW)) u_issue (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ld_n(ld_n),
        .sel_ok(sel_ok), .wr_n(wr_n), .burst_lin(burst_lin), .addr(addr),
        .issue_vld(issue_vld), .issue_wr(issue_wr),
        .issue_addr(issue_addr), .st(st)
    );

    zt_pipe #(.AW(AW), .NB(NB)) u_pipe (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n),
        .issue_vld(issue_vld), .issue_wr(issue_wr),
        .issue_addr(issue_addr), .issue_bwe_n(byte_we_n),
        .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr), .s1_bwe_n(s1_bwe_n),
        .s2_vld(s2_vld), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_bwe_n(s2_bwe_n)
    );

    zt_store #(.AW(AW), .NB(NB), .BW(BW)) u_store (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n),
        .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr),
        .s2_vld(s2_vld), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_bwe_n(s2_bwe_n),
        .din(dq), .dout(dout)
    );

    assign dq_oe = s2_vld && !s2_wr && !oe_n;
    assign dq    = dq_oe ? dout : {DW{1'bz}};
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
    import zt_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cke_n,
    input logic      ld_n,
    input logic      cs1_n,
    input logic      cs2,
    input logic      cs3_n,
    input logic      oe_n,
    input logic      s1_vld,
    input logic      s1_wr,
    input logic      s2_vld,
    input logic      s2_wr,
    input logic      dq_oe,
    input burst_st_e st
);
    AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_vld && !s1_wr) |=> (s2_vld && !s2_wr)); // R1

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(s1_vld) && $stable(s2_vld) && $stable(st))); // R4

    AST_DESEL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !ld_n && (cs1_n || !cs2 || cs3_n)) |=> (st == ST_IDLE && !s1_vld)); // R5

    AST_IDLE_ADV_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && ld_n && st == ST_IDLE) |=> !s1_vld); // R5

    AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_vld && s1_wr) |=> !dq_oe); // R6

    AST_OE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe); // R7
endmodule

bind zt_sram zt_sram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ld_n(ld_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .oe_n(oe_n),
    .s1_vld(s1_vld), .s1_wr(s1_wr), .s2_vld(s2_vld), .s2_wr(s2_wr),
    .dq_oe(dq_oe), .st(st)
);

// File: tb/sim_zt_sram.sv
`timescale 1ns/1ps
module sim_zt_sram;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int BW = 9;
    localparam int DW = NB * BW;
    localparam logic [DW-1:0] ZV = '1;   // released bus reads as all ones (pull-ups)

    logic          clk = 1'b0;
    logic          rst_n, cke_n, cs1_n, cs2, cs3_n, ld_n, wr_n, oe_n, burst_lin;
    logic [NB-1:0] byte_we_n;
    logic [AW-1:0] addr;
    logic          tb_drv;
    logic [DW-1:0] tb_dat;
    wire  [DW-1:0] dq;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done  = 0;

    always #2.5 clk = ~clk;

    assign dq = tb_drv ? tb_dat : {DW{1'bz}};
    for (genvar i = 0; i < DW; i++) begin : g_pu
        pullup (dq[i]);
    end

    zt_sram #(.AW(AW), .NB(NB), .BW(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .ld_n(ld_n), .wr_n(wr_n), .byte_we_n(byte_we_n),
        .oe_n(oe_n), .burst_lin(burst_lin), .addr(addr), .dq(dq)
    );

    function automatic logic [DW-1:0] val(input int a);
        return 36'h5_0000_0000 | (36'(a) * 36'h0_0101_0103);
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                            input logic [NB-1:0] bwe);
        logic [DW-1:0] r = o;
        for (int l = 0; l < NB; l++) if (!bwe[l]) r[l*BW +: BW] = n[l*BW +: BW];
        return r;
    endfunction

    task automatic idle_in();
        ld_n = 1'b0; cs1_n = 1'b1; cs2 = 1'b1; cs3_n = 1'b0;
        wr_n = 1'b1; byte_we_n = '1; addr = '0;
        tb_drv = 1'b0; tb_dat = '0; cke_n = 1'b0; oe_n = 1'b0;
    endtask

    task automatic nxt();
        @(negedge clk);
        idle_in();
    endtask

    task automatic cmd(input bit wr, input int a, input logic [NB-1:0] bwe);
        ld_n = 1'b0; cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
        wr_n = !wr; addr = AW'(a); byte_we_n = bwe;
    endtask

    task automatic drive(input logic [DW-1:0] d);
        tb_drv = 1'b1; tb_dat = d;
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] exp);
        #1;
        n_cmp++;
        if (dq !== exp) begin
            n_bad++;
            $display("FAIL %s: dq=%h expected=%h", tag, dq, exp);
        end
    endtask

    task automatic wr_word(input int a, input logic [DW-1:0] d, input logic [NB-1:0] bwe);
        nxt(); cmd(1, a, bwe);
        nxt();
        nxt(); drive(d);
    endtask

    task automatic rd_word(input int a, input logic [DW-1:0] exp, input string tag);
        nxt(); cmd(0, a, '1);
        nxt();
        nxt(); chk(tag, exp);
    endtask

    task automatic t_reset();
        idle_in();
        rst_n = 1'b0; burst_lin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); chk("R10 bus released in reset", ZV);
        rst_n = 1'b1;
        nxt(); chk("R10 bus released after reset", ZV);
    endtask

    task automatic t_basic();
        wr_word(5, val(5), '0);
        nxt(); cmd(0, 5, '1);
        nxt(); chk("R6 idle slot before read data", ZV);
        nxt(); chk("R1 read two edges later", val(5));
        nxt(); chk("R6 released after read slot", ZV);
    endtask

    task automatic t_b2b();
        wr_word(21, val(21), '0);
        nxt(); cmd(1, 20, '0);
        nxt(); cmd(0, 21, '1);
        nxt(); cmd(1, 22, '0); drive(val(20));
        nxt(); cmd(0, 20, '1); chk("R2 read after write, no gap", val(21));
        nxt(); drive(val(22));
        nxt(); chk("R2 write-read-write data", val(20));
        rd_word(22, val(22), "R2 write after read stored");
    endtask

    task automatic t_mask();
        wr_word(40, val(40), '0);
        wr_word(40, val(7), 4'b1010);
        rd_word(40, merge(val(40), val(7), 4'b1010), "R3 byte lanes 0 and 2 only");
    endtask

    task automatic t_forward();
        wr_word(30, val(30), '0);
        nxt(); cmd(1, 30, 4'b0011);
        nxt(); cmd(0, 30, '1);
        nxt(); drive(val(3));
        nxt(); chk("R9 read right after write merges", merge(val(30), val(3), 4'b0011));
    endtask

    task automatic t_stall();
        wr_word(50, val(50), '0);
        wr_word(51, val(51), '0);
        nxt(); cmd(0, 50, '1);
        nxt();
        nxt(); chk("R1 read data before stall", val(50));
        cke_n = 1'b1; cmd(1, 51, '0);
        nxt(); cke_n = 1'b1; cmd(1, 51, '0); chk("R4 bus held during stall", val(50));
        nxt(); chk("R4 bus held after stall", val(50));
        nxt(); chk("R4 released after resume", ZV);
        rd_word(51, val(51), "R4 stalled write ignored");
        nxt(); cmd(0, 50, '1);
        nxt(); cke_n = 1'b1;
        nxt(); cke_n = 1'b1;
        nxt(); chk("R4 stall delays read", ZV);
        nxt(); chk("R4 delayed read arrives", val(50));
    endtask

    task automatic t_burst(input bit lin);
        int seq[5];
        for (int k = 0; k < 5; k++) seq[k] = lin ? (8 + ((1 + k) % 4)) : (8 + (1 ^ (k % 4)));
        for (int k = 0; k < 7; k++) begin
            nxt();
            burst_lin = lin;
            if (k == 0) cmd(0, 9, '1);
            else if (k <= 4) ld_n = 1'b1;
            if (k >= 2) chk(lin ? "R8 linear beat" : "R8 interleaved beat", val(seq[k-2]));
        end
    endtask

    task automatic t_deselect();
        nxt(); cmd(0, 9, '1); burst_lin = 1'b1;
        nxt(); ld_n = 1'b1;
        nxt(); chk("R5 read before deselect", val(9));
        nxt(); ld_n = 1'b1; chk("R5 pending burst beat completes", val(10));
        nxt(); ld_n = 1'b1; chk("R5 deselect issues nothing", ZV);
        nxt(); chk("R5 advance after deselect idle", ZV);
        for (int c = 0; c < 3; c++) begin
            nxt(); cmd(0, 9, '1);
            cs1_n = (c == 0); cs2 = (c != 1); cs3_n = (c == 2);
            nxt(); ld_n = 1'b1;
            nxt(); chk("R5 single chip select off", ZV);
            nxt(); chk("R5 no burst after deselect", ZV);
        end
    endtask

    task automatic t_oe();
        nxt(); cmd(0, 9, '1);
        nxt(); cmd(0, 10, '1);
        nxt(); oe_n = 1'b1; chk("R7 output enable off", ZV);
        nxt(); chk("R7 pipeline intact after oe", val(10));
    endtask

    initial begin
        t_reset();
        for (int a = 8; a < 12; a++) wr_word(a, val(a), '0);
        t_basic();
        t_b2b();
        t_mask();
        t_forward();
        t_stall();
        t_burst(1'b1);
        t_burst(1'b0);
        t_deselect();
        t_oe();
        nxt(); nxt();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule